// File: doc/BRIEF.md
# Planar Read Path with Color Compare

This block forms the byte a processor sees when it reads display memory that is split into four bit planes. Each read presents four plane bytes fetched from one address. The block returns either the byte of one chosen plane, or an 8-bit map with one bit per pixel that tells whether that pixel's colour equals a reference colour. In the colour case, any plane can be left out of the comparison. Every read also copies the four plane bytes into latches, which the write datapath uses next.

Software reaches the configuration through an index/data register pair. A write with `port_sel` low picks a register index. A write with `port_sel` high stores data into the register that index names. The colour reference, the plane-compare enables, the plane select and the read mode all live behind this pair.

Top module: `gfx_read_path`

## Requirements
- R1: After reset, `rd_data` and all four latches are 0, the read mode is plane select, the selected plane is 0, and the compare reference and the plane enables are 0.
- R2: A port write with `port_sel`=0 stores `port_din[3:0]` as the register index. A write with `port_sel`=1 updates the register that index names: index 2 is the compare colour (bits 3:0), index 4 is the plane select (bits 1:0), index 5 is the mode (bit 3 is the read mode, and its other bits are ignored here), and index 7 holds the plane enables (bits 3:0). Data writes to any other index change nothing.
- R3: In read mode 0, a read returns the byte of the plane named by the plane select.
- R4: In read mode 1, bit i of the result is 1 exactly when, for every plane p whose enable bit p is 1, bit i of plane p equals bit p of the compare colour.
- R5: In read mode 1, if all four enable bits are 0, the result is 0xFF.
- R6: Every read loads latch p with plane byte p, in either read mode.
- R7: When `rd_stb` is low, `rd_data` and the latches keep their values.
- R8: Only the bits named in R2 take effect. The upper bits of the compare colour, plane enable and plane select writes are ignored.
- R9: The result and the latches of a read appear on the clock edge that samples `rd_stb` high. A register write takes effect from the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr | input | 1 | Register port write strobe |
| port_sel | input | 1 | 0 selects an index write, 1 selects a data write |
| port_din | input | 8 | Register port write data |
| rd_stb | input | 1 | Read strobe; the plane bytes are valid during this cycle |
| plane_d | input | 32 | Four plane bytes; plane p is bits 8p+7:8p |
| rd_data | output | 8 | Read result |
| latch_q | output | 32 | Four latches; latch p is bits 8p+7:8p |

## Verification
Both the read result and the latches are registered once. A value that the read strobe presents at one rising edge is visible right after that edge, and it holds until the next strobe. Register writes work the same way, one edge each. The bench drives every input on the falling edge and applies the strobe for exactly one rising edge. It samples at the next falling edge, which is half a cycle after the result is due. During hold checks it changes the plane inputs with the strobe low, so a wrong capture would show at the ports.

// File: rtl/gfx_read_path.sv
module gfx_read_path #(
  parameter int W  = 8,
  parameter int NP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_wr,
  input  logic            port_sel,
  input  logic [7:0]      port_din,
  input  logic            rd_stb,
  input  logic [NP*W-1:0] plane_d,
  output logic [W-1:0]    rd_data,
  output logic [NP*W-1:0] latch_q
);
  localparam int SW = $clog2(NP);

  logic [3:0]    idx;
  logic          rmode;
  logic [SW-1:0] psel;
  logic [NP-1:0] cmp_col;
  logic [NP-1:0] cmp_en;
  logic [W-1:0]  match;
  logic [W-1:0]  sel_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      rmode   <= 1'b0;
      psel    <= '0;
      cmp_col <= '0;
      cmp_en  <= '0;
    end else if (port_wr) begin
      if (!port_sel) idx <= port_din[3:0];
      else begin
        case (idx)
          4'd2: cmp_col <= port_din[NP-1:0];
          4'd4: psel    <= port_din[SW-1:0];
          4'd5: rmode   <= port_din[3];
          4'd7: cmp_en  <= port_din[NP-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pix
    logic [NP-1:0] col;
    for (genvar p = 0; p < NP; p++) begin : g_pl
      assign col[p] = plane_d[p*W+i];
    end
    assign match[i] = &(~cmp_en | ~(col ^ cmp_col));
  end

  assign sel_byte = plane_d[psel*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      latch_q <= '0;
    end else if (rd_stb) begin
      rd_data <= rmode ? match : sel_byte;
      latch_q <= plane_d;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data) && $stable(latch_q)); // R7
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> latch_q == $past(plane_d)); // R6
  AST_ALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rmode && cmp_en == '0 |=> rd_data == '1); // R5
  AST_PLANE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !rmode |=> rd_data == $past(plane_d[psel*W +: W])); // R3
  AST_UNMAPPED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr && port_sel && idx == 4'd0 |=> $stable(cmp_col) && $stable(cmp_en) && $stable(psel) && $stable(rmode)); // R2
endmodule

// File: tb/gfx_read_path_bench.sv
module gfx_read_path_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        port_wr = 0, port_sel = 0, rd_stb = 0;
  logic [7:0]  port_din = 0;
  logic [31:0] plane_d = 0;
  logic [7:0]  rd_data;
  logic [31:0] latch_q;
  int errors = 0, checks = 0;
  logic done = 0;

  always #5 clk = ~clk;

  gfx_read_path u_gfx_read_path (.clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_sel(port_sel),
    .port_din(port_din), .rd_stb(rd_stb), .plane_d(plane_d), .rd_data(rd_data), .latch_q(latch_q));

  // mode, plane select, compare colour, enables, planes {p3,p2,p1,p0}, expected
  typedef struct packed { logic m; logic [7:0] s; logic [7:0] c; logic [7:0] e; logic [31:0] pl; logic [7:0] x; } vec_t;
  localparam vec_t VEC [10] = '{
    '{1'b0, 8'h00, 8'h0, 8'h0, 32'h44332211, 8'h11}, // R3
    '{1'b0, 8'h03, 8'h0, 8'h0, 32'h44332211, 8'h44}, // R3
    '{1'b0, 8'hFE, 8'h0, 8'h0, 32'h00FF5AA5, 8'hFF}, // R8 select bits 1:0 only
    '{1'b1, 8'h00, 8'hF, 8'hF, 32'h00FFFFFF, 8'h00}, // R4
    '{1'b1, 8'h00, 8'h7, 8'hF, 32'h00FFFFFF, 8'hFF}, // R4
    '{1'b1, 8'h00, 8'h5, 8'hF, 32'h00F000F0, 8'hF0}, // R4
    '{1'b1, 8'h00, 8'hF5, 8'hF1, 32'hFF0000F0, 8'hF0}, // R8 upper bits ignored
    '{1'b1, 8'h00, 8'h0, 8'h0, 32'h78563412, 8'hFF}, // R5
    '{1'b1, 8'h00, 8'h0, 8'h8, 32'h3C00000F, 8'hC3}, // R4
    '{1'b1, 8'h00, 8'h2, 8'h3, 32'h0000CCAA, 8'h44}  // R4
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pw(logic sel, logic [7:0] d);
    @(negedge clk); port_wr = 1; port_sel = sel; port_din = d;
    @(negedge clk); port_wr = 0;
  endtask

  task automatic wreg(logic [7:0] i, logic [7:0] d);
    pw(0, i); pw(1, d);
  endtask

  task automatic rd(logic [31:0] pl);
    @(negedge clk); plane_d = pl; rd_stb = 1;
    @(negedge clk); rd_stb = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 latch", latch_q, 0);
    rst_n = 1;
    rd(32'h12345678);
    chk("R1 default plane 0", rd_data, 8'h78);
    wreg(5, 8'h08);
    rd(32'h0A0B0C0D);
    chk("R1 R5 reset enables give FF", rd_data, 8'hFF);

    for (int k = 0; k < 10; k++) begin
      wreg(5, VEC[k].m ? 8'h0B : 8'h03);
      wreg(4, VEC[k].s);
      wreg(2, VEC[k].c);
      wreg(7, VEC[k].e);
      rd(VEC[k].pl);
      chk($sformatf("R3/R4/R5/R8 vector %0d", k), rd_data, VEC[k].x);
      chk($sformatf("R6 vector %0d latch", k), latch_q, VEC[k].pl);
    end

    // R7: hold with strobe low
    @(negedge clk); plane_d = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    chk("R7 rd_data hold", rd_data, 8'h44);
    chk("R7 latch hold", latch_q, 32'h0000CCAA);

    // R2: data write to unmapped index 0 changes nothing
    wreg(0, 8'hFF);
    rd(32'h0000CCAA);
    chk("R2 unmapped index", rd_data, 8'h44);

    // R2: index persists across data writes
    pw(0, 7); pw(1, 8'h0); pw(1, 8'h1);
    rd(32'h000000F0);
    chk("R2 index kept", rd_data, 8'h0F);

    // R9: one-cycle latency of read and register write
    @(negedge clk); port_wr = 1; port_sel = 0; port_din = 5;
    @(negedge clk); port_din = 8'h00; port_sel = 1;
    @(negedge clk); port_wr = 0; plane_d = 32'h11223344; rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    chk("R9 mode write then read", rd_data, 8'h44);
    chk("R9 latch", latch_q, 32'h11223344);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule